// File: doc/BRIEF.md
# Execute-Stage ALU and Barrel Shifter

This block is the execute stage of a 32-bit RISC datapath. It holds two operand registers, a ten-operation arithmetic/logic unit and a barrel shifter. Operand register A captures either a register-file value or the stage's own current result. That forwarding path lets an instruction use the result of the instruction just before it without a bubble. Operand register B captures either a register-file value or an immediate. Decode and hazard logic sit outside the block and supply every selection as a control input.

The ALU and shifter are combinational from the two operand registers. An output select picks which of them drives the result. Four flags come with the result: signed overflow, zero, negative and carry. For subtraction the carry flag reports a borrow. All flags reflect the value presented on the result port.

Top module: `exu_core`

## Requirements
- R1: A synchronous active-low reset clears both operand registers. After reset with operation code 0, carry-in 0 and the ALU selected, the result is 0 with zero=1 and negative, overflow and carry all 0.
- R2: An operand register loads only on a clock edge where its load enable is high. With the enable low it keeps its value, so the result does not change.
- R3: When the immediate select is high, register B loads the immediate input instead of the register-file B input.
- R4: When the bypass select is high, register A loads the result currently on the output port. A dependent add therefore sees the previous result.
- R5: Code 0 computes A+B and code 1 computes A+B+cin. The carry flag is the unsigned carry out of bit 31.
- R6: Code 2 computes A−B and code 3 computes A−B−cin. The carry flag is 1 exactly when the unsigned subtraction borrows.
- R7: Code 4 computes A and B, 5 computes A and not B, 6 computes A or B, 7 computes A or not B, 8 computes A xor B and 9 computes A xor not B. Carry and overflow are 0 for these codes.
- R8: For codes 0 to 3 the overflow flag is 1 exactly when the true signed result falls outside the 32-bit two's-complement range.
- R9: The zero flag is 1 when the output result is all zeros. The negative flag equals bit 31 of the output result.
- R10: With the shift select high, the result is A shifted by B[4:0]; bits 31..5 of B have no effect. shift_right=0 gives a logical left shift whatever the arithmetic bit is. shift_right=1 with shift_arith=0 gives a logical right shift, and with shift_arith=1 an arithmetic right shift.
- R11: With the shift select high, overflow and carry are 0.
- R12: Operation codes 10 to 15 yield a result of 0 with overflow and carry both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rf_a | input | 32 | Register-file operand for A |
| rf_b | input | 32 | Register-file operand for B |
| imm | input | 32 | Immediate operand for B |
| a_load | input | 1 | Load enable for register A |
| b_load | input | 1 | Load enable for register B |
| a_sel_bypass | input | 1 | 1: A loads the current result |
| b_sel_imm | input | 1 | 1: B loads the immediate |
| op | input | 4 | ALU operation code (0..9; 10..15 reserved) |
| cin | input | 1 | Carry/borrow input for codes 1 and 3 |
| shift_arith | input | 1 | 1: arithmetic right shift |
| shift_right | input | 1 | 1: shift right, 0: shift left |
| out_sel_shift | input | 1 | 1: result from shifter, 0: from ALU |
| result | output | 32 | Stage result |
| flag_v | output | 1 | Signed overflow |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 31 |
| flag_c | output | 1 | Carry out or borrow |

## Verification
Operands captured at a rising edge appear at the result and flags in that same cycle, because only the operand registers sit on the path. Operation, carry-in and shift controls act combinationally on the registered operands. The bench therefore changes all inputs at a falling edge and lets the rising edge load the operands. It compares result and flags at the next falling edge, one half-cycle after the load. For the bypass and hold cases, one further rising edge separates the observed result from the one that was captured into A.

// File: rtl/exu_pkg.sv
// Package: shared operation codes for the execute stage.
// Assumes a 4-bit operation field; codes 10..15 are reserved.
package exu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_AND  = 4'd4,
        OP_ANDN = 4'd5,
        OP_OR   = 4'd6,
        OP_ORN  = 4'd7,
        OP_XOR  = 4'd8,
        OP_XORN = 4'd9
    } exu_op_e;
endpackage

// File: rtl/exu_opnd_regs.sv
// Module: operand registers A and B with their source selection.
// A takes the register file or the bypassed result; B takes the register
// file or the immediate. Assumes a synchronous active-low reset.
module exu_opnd_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rf_a,
    input  logic [W-1:0] rf_b,
    input  logic [W-1:0] imm,
    input  logic [W-1:0] byp,
    input  logic         a_load,
    input  logic         b_load,
    input  logic         a_sel_bypass,
    input  logic         b_sel_imm,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q
);
    // Register A: clear on reset, else load the selected source when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            a_q <= '0;
        else if (a_load)
            a_q <= a_sel_bypass ? byp : rf_a;
    end

    // Register B: clear on reset, else load the selected source when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            b_q <= '0;
        else if (b_load)
            b_q <= b_sel_imm ? imm : rf_b;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (a_q == '0 && b_q == '0));
    a_r2_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        !a_load |=> $stable(a_q));
    a_r2_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        !b_load |=> $stable(b_q));
    a_r3_imm_load: assert property (@(posedge clk) disable iff (!rst_n)
        (b_load && b_sel_imm) |=> (b_q == $past(imm)));
    a_r4_bypass_load: assert property (@(posedge clk) disable iff (!rst_n)
        (a_load && a_sel_bypass) |=> (a_q == $past(byp)));
endmodule

// File: rtl/exu_alu.sv
// Module: ten-operation ALU sharing one adder for all arithmetic codes.
// Subtraction is A + ~B + 1; subtract-with-borrow is A + ~B + ~cin.
// Carry reports a borrow for subtraction. Reserved codes give zero.
module exu_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   op,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         v,
    output logic         c
);
    import exu_pkg::*;

    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic         ci;
    logic         is_arith;
    logic         is_sub;
    logic [W:0]   sum;

    // Operand conditioning and result/flag selection for the current code
    always_comb begin
        b_eff    = b;
        ci       = 1'b0;
        is_arith = 1'b0;
        is_sub   = 1'b0;
        case (exu_op_e'(op))
            OP_ADD:  begin is_arith = 1'b1; end
            OP_ADDC: begin is_arith = 1'b1; ci = cin; end
            OP_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; b_eff = ~b; ci = 1'b1; end
            OP_SUBC: begin is_arith = 1'b1; is_sub = 1'b1; b_eff = ~b; ci = ~cin; end
            default: ;
        endcase
        sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci};
        case (exu_op_e'(op))
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: res = sum[W-1:0];
            OP_AND:  res = a & b;
            OP_ANDN: res = a & ~b;
            OP_OR:   res = a | b;
            OP_ORN:  res = a | ~b;
            OP_XOR:  res = a ^ b;
            OP_XORN: res = a ^ ~b;
            default: res = '0;
        endcase
        v = is_arith & (a[MSB] == b_eff[MSB]) & (sum[MSB] != a[MSB]);
        c = is_arith & (is_sub ? ~sum[W] : sum[W]);
    end

    // R6: equal operands subtract to zero with no borrow and no overflow
    always_comb begin
        if (!$isunknown({a, b, op}) && op == 4'd2 && a == b)
            a_r6_sub_equal: assert (res == '0 && !c && !v);
    end
endmodule

// File: rtl/exu_shifter.sv
// Module: logarithmic barrel shifter. A left shift reuses the right-shift
// network by bit-reversing input and output. Arithmetic fill applies only
// to right shifts; a left shift is always logical.
module exu_shifter #(
    parameter int W = 32
) (
    input  logic [W-1:0]          a,
    input  logic [$clog2(W)-1:0]  cnt,
    input  logic                  arith,
    input  logic                  right,
    output logic [W-1:0]          y
);
    localparam int CW = $clog2(W);

    logic [W-1:0] a_rev;
    logic [W-1:0] y_rev;
    logic [W-1:0] stage [CW+1];
    logic         fill;

    // Reverse the bit order for the left-shift path
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign a_rev[i] = a[W-1-i];
        assign y_rev[i] = stage[CW][W-1-i];
    end

    // Fill bit: sign only for an arithmetic right shift
    assign fill     = right & arith & a[W-1];
    assign stage[0] = right ? a : a_rev;

    // One stage per count bit, each shifting by a power of two
    for (genvar s = 0; s < CW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stage[s+1] = cnt[s] ? {{D{fill}}, stage[s][W-1:D]} : stage[s];
    end

    // Undo the reversal for left shifts
    assign y = right ? stage[CW] : y_rev;

    // R10: zero count passes A through, left shift clears bit 0
    always_comb begin
        if (!$isunknown({a, cnt, arith, right})) begin
            if (cnt == '0)
                a_r10_zero_count: assert (y == a);
            if (!right && cnt != '0)
                a_r10_left_fill: assert (y[0] == 1'b0);
        end
    end
endmodule

// File: rtl/exu_core.sv
// Module: execute stage top. Operand registers feed the ALU and shifter.
// The output select picks one result, and zero/negative come from it.
// The result also feeds back as the bypass source for register A.
module exu_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] imm,
    input  logic              a_load,
    input  logic              b_load,
    input  logic              a_sel_bypass,
    input  logic              b_sel_imm,
    input  logic [3:0]        op,
    input  logic              cin,
    input  logic              shift_arith,
    input  logic              shift_right,
    input  logic              out_sel_shift,
    output logic [DATA_W-1:0] result,
    output logic              flag_v,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_c
);
    localparam int CW = $clog2(DATA_W);

    logic [DATA_W-1:0] a_q, b_q, alu_res, sh_res;
    logic              alu_v, alu_c;

    exu_opnd_regs #(.W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .rf_a(rf_a), .rf_b(rf_b), .imm(imm),
        .byp(result), .a_load(a_load), .b_load(b_load),
        .a_sel_bypass(a_sel_bypass), .b_sel_imm(b_sel_imm),
        .a_q(a_q), .b_q(b_q)
    );

    exu_alu #(.W(DATA_W)) u_alu (
        .a(a_q), .b(b_q), .op(op), .cin(cin),
        .res(alu_res), .v(alu_v), .c(alu_c)
    );

    exu_shifter #(.W(DATA_W)) u_shift (
        .a(a_q), .cnt(b_q[CW-1:0]), .arith(shift_arith), .right(shift_right),
        .y(sh_res)
    );

    // Output select; arithmetic flags are cleared for shifts
    always_comb begin
        result = out_sel_shift ? sh_res : alu_res;
        flag_v = out_sel_shift ? 1'b0 : alu_v;
        flag_c = out_sel_shift ? 1'b0 : alu_c;
        flag_z = (result == '0);
        flag_n = result[DATA_W-1];
    end
endmodule

// File: tb/exu_core_test.sv
module exu_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rf_a = '0, rf_b = '0, imm = '0;
    logic        a_load = 1'b0, b_load = 1'b0, a_sel_bypass = 1'b0, b_sel_imm = 1'b0;
    logic [3:0]  op = '0;
    logic        cin = 1'b0, shift_arith = 1'b0, shift_right = 1'b0, out_sel_shift = 1'b0;
    logic [31:0] result;
    logic        flag_v, flag_z, flag_n, flag_c;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    exu_core uut (
        .clk(clk), .rst_n(rst_n), .rf_a(rf_a), .rf_b(rf_b), .imm(imm),
        .a_load(a_load), .b_load(b_load), .a_sel_bypass(a_sel_bypass),
        .b_sel_imm(b_sel_imm), .op(op), .cin(cin), .shift_arith(shift_arith),
        .shift_right(shift_right), .out_sel_shift(out_sel_shift),
        .result(result), .flag_v(flag_v), .flag_z(flag_z), .flag_n(flag_n),
        .flag_c(flag_c)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] val(int i);
        case (i)
            0: val = 32'h0000_0000;
            1: val = 32'h0000_0001;
            2: val = 32'h7FFF_FFFF;
            3: val = 32'h8000_0000;
            4: val = 32'hFFFF_FFFF;
            5: val = 32'h1234_5678;
            6: val = 32'hA5A5_A5A5;
            default: val = 32'h0000_0005;
        endcase
    endfunction

    // Reference model: {result, v, c, z, n}
    function automatic logic [35:0] model(logic [31:0] a, logic [31:0] b, int opc,
                                          logic ci, logic sel, logic ar, logic rt);
        logic [31:0] r;
        logic vv, cc;
        longint ua, ub, sa, sb, sr;
        int n;
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        vv = 0; cc = 0; r = '0; sr = 0;
        if (sel) begin
            n = int'(b[4:0]);
            if (!rt) r = a << n;
            else if (ar) r = $signed(a) >>> n;
            else r = a >> n;
        end else begin
            case (opc)
                0: begin r = a + b; cc = (ua + ub) > 64'hFFFF_FFFF; sr = sa + sb; end
                1: begin r = a + b + 32'(ci); cc = (ua + ub + longint'(ci)) > 64'hFFFF_FFFF;
                         sr = sa + sb + longint'(ci); end
                2: begin r = a - b; cc = ua < ub; sr = sa - sb; end
                3: begin r = a - b - 32'(ci); cc = ua < (ub + longint'(ci));
                         sr = sa - sb - longint'(ci); end
                4: r = a & b;
                5: r = a & ~b;
                6: r = a | b;
                7: r = a | ~b;
                8: r = a ^ b;
                9: r = a ^ ~b;
                default: r = '0;
            endcase
            if (opc <= 3) vv = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        end
        model = {r, vv, cc, (r == 32'd0), r[31]};
    endfunction

    function automatic string tag(int opc, logic sel);
        if (sel) tag = "R10/R11";
        else if (opc <= 1) tag = "R5/R8/R9";
        else if (opc <= 3) tag = "R6/R8/R9";
        else if (opc <= 9) tag = "R7/R9";
        else tag = "R12";
    endfunction

    task automatic compare(logic [35:0] exp, string req);
        logic [35:0] act;
        act = {result, flag_v, flag_c, flag_z, flag_n};
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual res=%h v=%b c=%b z=%b n=%b expected res=%h v=%b c=%b z=%b n=%b",
                     req, act[35:4], act[3], act[2], act[1], act[0],
                     exp[35:4], exp[3], exp[2], exp[1], exp[0]);
        end
    endtask

    // Load both operands from the register file, then check at the next falling edge
    task automatic run(logic [31:0] a, logic [31:0] b, int opc, logic ci,
                       logic sel, logic ar, logic rt);
        @(negedge clk);
        rf_a = a; rf_b = b; a_load = 1; b_load = 1; a_sel_bypass = 0; b_sel_imm = 0;
        op = 4'(opc); cin = ci; out_sel_shift = sel; shift_arith = ar; shift_right = rt;
        @(posedge clk);
        @(negedge clk);
        a_load = 0; b_load = 0;
        compare(model(a, b, opc, ci, sel, ar, rt), tag(opc, sel));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        compare({32'd0, 1'b0, 1'b0, 1'b1, 1'b0}, "R1");
        rst_n = 1;

        // ALU sweep over all codes, operand pairs and carry-in values
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int k = 0; k < 2; k++)
                        run(val(i), val(j), o, k[0], 1'b0, 1'b0, 1'b0);

        // Shifter sweep: every count, three modes, upper bits of B set (R10)
        for (int m = 0; m < 4; m++)
            for (int cnt = 0; cnt < 32; cnt++)
                for (int i = 2; i < 7; i++)
                    run(val(i), {27'h5A5A5A5, 5'(cnt)}, 0, 1'b0, 1'b1, m[1], m[0]);

        // R3: immediate replaces register-file B
        @(negedge clk);
        rf_a = 32'd40; rf_b = 32'd3; imm = 32'd100; a_load = 1; b_load = 1;
        b_sel_imm = 1; a_sel_bypass = 0; op = 4'd0; cin = 0; out_sel_shift = 0;
        @(posedge clk);
        @(negedge clk);
        a_load = 0; b_load = 0; b_sel_imm = 0;
        compare(model(32'd40, 32'd100, 0, 1'b0, 1'b0, 1'b0, 1'b0), "R3");

        // R4: bypass loads the previous result (140) into A; B stays 100
        @(negedge clk);
        a_load = 1; a_sel_bypass = 1; rf_a = 32'hDEAD_BEEF;
        @(posedge clk);
        @(negedge clk);
        a_load = 0; a_sel_bypass = 0;
        compare(model(32'd140, 32'd100, 0, 1'b0, 1'b0, 1'b0, 1'b0), "R4");

        // R2: loads disabled, new register-file values are ignored
        @(negedge clk);
        rf_a = 32'h1111_1111; rf_b = 32'h2222_2222; imm = 32'h3; b_sel_imm = 1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        b_sel_imm = 0;
        compare(model(32'd140, 32'd100, 0, 1'b0, 1'b0, 1'b0, 1'b0), "R2");

        // R1: reset mid-run clears the operands again
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare({32'd0, 1'b0, 1'b0, 1'b1, 1'b0}, "R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule